// File: doc/BRIEF.md
# Ethernet Frame Encapsulator

This block turns a raw Ethernet payload (destination address through the last data byte) into a complete frame on a byte stream. The payload enters as bytes with first and last markers and a valid/ready handshake. The block puts a seven-byte preamble and a start delimiter in front of it. It pads short payloads with zeros up to the minimum size and appends a 32-bit CRC frame check sequence. The frame leaves on a second valid/ready byte stream with its own first and last markers.

The payload length is given alongside the first input byte. This lets the block decide before emitting anything whether the frame fits a destination buffer of `BUF_SIZE` bytes. A frame that does not fit is swallowed without output. For every frame the block reports the total number of bytes emitted, which is zero for a dropped frame.

Top module: `eth_frame_encap`

## Requirements
- R1: After reset, with no input offered, `out_valid_o`, `in_ready_o` and `len_valid_o` are all low.
- R2: Each accepted frame begins with `PRE_LEN` (7) bytes of 0x55 followed by one 0xD5 byte. `out_first_o` is high only on the first 0x55 byte.
- R3: After the 0xD5 byte, the payload bytes pass through in arrival order. `in_ready_o` stays low while preamble, delimiter, padding or check bytes are emitted.
- R4: A payload shorter than `MIN_PAY` (60) bytes is followed by 0x00 bytes until `MIN_PAY` payload-plus-pad bytes have been emitted. A payload of `MIN_PAY` bytes or more gets no padding.
- R5: The final four bytes are a CRC-32 over payload and padding only, least significant byte first. The CRC uses the bit-reversed polynomial 0xEDB88320 (reflected 0x04C11DB7), starts from 0xFFFFFFFF and is inverted at the end. `out_last_o` is high only on the fourth check byte.
- R6: One cycle after the last check byte is accepted, `len_valid_o` pulses for one cycle with `len_o` equal to the padded payload length plus 12 and `drop_o` low.
- R7: If `in_len_i` plus 12 exceeds `BUF_SIZE`, the block emits no byte. It consumes input bytes through the one marked last, then pulses `len_valid_o` with `len_o` = 0 and `drop_o` high. A sum exactly equal to `BUF_SIZE` is accepted.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output byte is held (given a held input during payload). No byte is lost or repeated under any backpressure pattern.
- R9: Input bytes offered between frames without `in_first_i` are consumed and discarded, producing no output and no length report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| in_data_i | input | 8 | Input payload byte |
| in_first_i | input | 1 | Marks the first payload byte |
| in_last_i | input | 1 | Marks the last payload byte |
| in_len_i | input | LEN_W | Payload length, sampled with the first byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| out_data_o | output | 8 | Output frame byte |
| out_first_o | output | 1 | First byte of the frame |
| out_last_o | output | 1 | Last byte of the frame |
| len_valid_o | output | 1 | One-cycle length report strobe |
| len_o | output | LEN_W | Emitted frame length, zero when dropped |
| drop_o | output | 1 | Frame was dropped for size |

## Verification
Payloads of 1, 10, 60, 64 and 116 bytes are encapsulated, with the buffer limit set to 128. The short cases separate the padding path from the pass-through path. Exactly 60 bytes separates a less-than from a less-or-equal pad boundary. The 116-byte frame lands exactly on the buffer limit, and a 117-byte frame one above it must be dropped. A 20-byte frame under a stalling `out_ready_i` pattern exposes lost or duplicated bytes. A stray unmarked byte between frames must vanish without disturbing the following frame.

// File: rtl/eth_encap_pkg.sv
`timescale 1ns/1ps
package eth_encap_pkg;
  localparam logic [7:0]  PRE_BYTE     = 8'h55;
  localparam logic [7:0]  SFD_BYTE     = 8'hD5;
  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam int          FCS_LEN      = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_PAY, ST_PAD, ST_FCS, ST_DROP
  } enc_state_e;

  typedef enum logic [2:0] {
    SEL_PRE, SEL_SFD, SEL_PAY, SEL_ZERO, SEL_FCS
  } enc_sel_e;
endpackage

// File: rtl/eth_crc32_byte.sv
`timescale 1ns/1ps
module eth_crc32_byte
  import eth_encap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;
  logic [31:0] stage [0:8];

  assign stage[0] = crc_q ^ {24'd0, data_i};

  for (genvar i = 0; i < 8; i++) begin : g_bit
    assign stage[i+1] = stage[i][0] ? ({1'b0, stage[i][31:1]} ^ CRC_POLY_REV)
                                    : {1'b0, stage[i][31:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= stage[8];
  end

  assign crc_o = ~crc_q;
endmodule

// File: rtl/eth_encap_fsm.sv
`timescale 1ns/1ps
module eth_encap_fsm
  import eth_encap_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int BUF_SIZE = 2048,
  parameter int MIN_PAY  = 60,
  parameter int PRE_LEN  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_first_i,
  input  logic             in_last_i,
  input  logic [LEN_W-1:0] in_len_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_first_o,
  output logic             out_last_o,
  output enc_sel_e         sel_o,
  output logic [1:0]       fcs_sel_o,
  output logic             crc_init_o,
  output logic             crc_en_o,
  output logic             len_valid_o,
  output logic [LEN_W-1:0] len_o,
  output logic             drop_o
);
  localparam int IDX_W = $clog2(PRE_LEN + FCS_LEN + 1);
  localparam int OVH   = PRE_LEN + 1 + FCS_LEN;
  localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] FCS_LAST = IDX_W'(FCS_LEN - 1);
  localparam logic [LEN_W-1:0] MIN_L    = LEN_W'(MIN_PAY);
  localparam logic [LEN_W-1:0] OVH_L    = LEN_W'(OVH);
  localparam logic [LEN_W:0]   BUF_LIM  = (LEN_W+1)'(BUF_SIZE);

  enc_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] pay_q, pay_inc;
  logic             fits;

  assign pay_inc   = pay_q + LEN_W'(1);
  assign fits      = ({1'b0, in_len_i} + (LEN_W+1)'(OVH)) <= BUF_LIM;
  assign fcs_sel_o = idx_q[1:0];

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_first_o = 1'b0;
    out_last_o  = 1'b0;
    sel_o       = SEL_ZERO;
    crc_init_o  = 1'b0;
    crc_en_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready_o = in_valid_i & ~in_first_i;  // discard stray bytes
        crc_init_o = 1'b1;
      end
      ST_PRE: begin
        out_valid_o = 1'b1;
        out_first_o = (idx_q == '0);
        sel_o       = (idx_q == PRE_LAST) ? SEL_SFD : SEL_PRE;
      end
      ST_PAY: begin
        out_valid_o = in_valid_i;
        in_ready_o  = out_ready_i;
        sel_o       = SEL_PAY;
        crc_en_o    = in_valid_i & out_ready_i;
      end
      ST_PAD: begin
        out_valid_o = 1'b1;
        crc_en_o    = out_ready_i;
      end
      ST_FCS: begin
        out_valid_o = 1'b1;
        out_last_o  = (idx_q == FCS_LAST);
        sel_o       = SEL_FCS;
      end
      ST_DROP: in_ready_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      pay_q       <= '0;
      len_o       <= '0;
      len_valid_o <= 1'b0;
      drop_o      <= 1'b0;
    end else begin
      len_valid_o <= 1'b0;
      drop_o      <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_valid_i && in_first_i) begin
          idx_q   <= '0;
          pay_q   <= '0;
          state_q <= fits ? ST_PRE : ST_DROP;
        end
        ST_PRE: if (out_ready_i) begin
          if (idx_q == PRE_LAST) begin
            idx_q   <= '0;
            state_q <= ST_PAY;
          end else idx_q <= idx_q + IDX_W'(1);
        end
        ST_PAY: if (in_valid_i && out_ready_i) begin
          pay_q <= pay_inc;
          if (in_last_i) state_q <= (pay_inc < MIN_L) ? ST_PAD : ST_FCS;
        end
        ST_PAD: if (out_ready_i) begin
          pay_q <= pay_inc;
          if (pay_inc >= MIN_L) state_q <= ST_FCS;
        end
        ST_FCS: if (out_ready_i) begin
          if (idx_q == FCS_LAST) begin
            idx_q       <= '0;
            state_q     <= ST_IDLE;
            len_o       <= pay_q + OVH_L;
            len_valid_o <= 1'b1;
          end else idx_q <= idx_q + IDX_W'(1);
        end
        ST_DROP: if (in_valid_i && in_last_i) begin
          state_q     <= ST_IDLE;
          len_o       <= '0;
          len_valid_o <= 1'b1;
          drop_o      <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eth_frame_encap.sv
`timescale 1ns/1ps
module eth_frame_encap
  import eth_encap_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int BUF_SIZE = 2048,
  parameter int MIN_PAY  = 60,
  parameter int PRE_LEN  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  input  logic             in_first_i,
  input  logic             in_last_i,
  input  logic [LEN_W-1:0] in_len_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_first_o,
  output logic             out_last_o,
  output logic             len_valid_o,
  output logic [LEN_W-1:0] len_o,
  output logic             drop_o
);
  enc_sel_e    sel;
  logic [1:0]  fcs_sel;
  logic        crc_init, crc_en;
  logic [31:0] crc_fin;

  eth_encap_fsm #(
    .LEN_W(LEN_W), .BUF_SIZE(BUF_SIZE), .MIN_PAY(MIN_PAY), .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_first_i  (in_first_i),
    .in_last_i   (in_last_i),
    .in_len_i    (in_len_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_first_o (out_first_o),
    .out_last_o  (out_last_o),
    .sel_o       (sel),
    .fcs_sel_o   (fcs_sel),
    .crc_init_o  (crc_init),
    .crc_en_o    (crc_en),
    .len_valid_o (len_valid_o),
    .len_o       (len_o),
    .drop_o      (drop_o)
  );

  // CRC consumes exactly what goes out during payload and padding
  eth_crc32_byte u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .en_i   (crc_en),
    .data_i (out_data_o),
    .crc_o  (crc_fin)
  );

  always_comb begin
    unique case (sel)
      SEL_PRE: out_data_o = PRE_BYTE;
      SEL_SFD: out_data_o = SFD_BYTE;
      SEL_PAY: out_data_o = in_data_i;
      SEL_FCS: out_data_o = crc_fin[{fcs_sel, 3'b000} +: 8];
      default: out_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/eth_frame_encap_chk.sv
`timescale 1ns/1ps
module eth_frame_encap_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_PAY = 60
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [7:0]       in_data_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [7:0]       out_data_o,
  input logic             out_first_o,
  input logic             out_last_o,
  input logic             len_valid_o,
  input logic [LEN_W-1:0] len_o,
  input logic             drop_o
);
  localparam logic [LEN_W-1:0] MIN_FRAME = LEN_W'(MIN_PAY + 12);

  AST_FIRST_IS_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_first_o |-> out_data_o == 8'h55); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && out_valid_o |-> out_data_o == in_data_i); // R3
  AST_LEN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_valid_o && !drop_o |-> len_o >= MIN_FRAME); // R4
  AST_LAST_THEN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> len_valid_o && !drop_o); // R6
  AST_LEN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_valid_o |=> !len_valid_o); // R6
  AST_DROP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> len_valid_o && len_o == '0); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !in_ready_o |=> out_valid_o && $stable(out_data_o)); // R8
endmodule

bind eth_frame_encap eth_frame_encap_chk #(.LEN_W(LEN_W), .MIN_PAY(MIN_PAY)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .out_first_o(out_first_o), .out_last_o(out_last_o),
  .len_valid_o(len_valid_o), .len_o(len_o), .drop_o(drop_o)
);

// File: tb/sim_eth_frame_encap.sv
`timescale 1ns/1ps
module sim_eth_frame_encap;
  localparam int LEN_W = 16;
  localparam int BUF   = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_first = 0, in_last = 0, out_ready = 1;
  logic [7:0] in_data = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic in_ready, out_valid, out_first, out_last, len_valid, drop;
  logic [7:0] out_data;
  logic [LEN_W-1:0] len;

  int checks = 0, failures = 0;
  bit bp_en = 0;
  int cyc = 0;
  logic [7:0] cap[$];
  bit capf[$], capl[$];
  int len_cnt = 0, last_len = 0, hold_err = 0;
  bit last_drop = 0, prev_stall = 0;
  logic [7:0] prev_data;

  always #10 clk = ~clk;

  eth_frame_encap #(.LEN_W(LEN_W), .BUF_SIZE(BUF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_first_i(in_first), .in_last_i(in_last), .in_len_i(in_len),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_first_o(out_first), .out_last_o(out_last), .len_valid_o(len_valid),
    .len_o(len), .drop_o(drop)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (prev_stall && (!out_valid || out_data != prev_data)) hold_err++;
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (out_valid && out_ready) begin
      cap.push_back(out_data); capf.push_back(out_first); capl.push_back(out_last);
    end
    if (len_valid) begin len_cnt++; last_len = int'(len); last_drop = drop; end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[k]) begin
      c ^= {24'd0, b[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic push_byte(logic [7:0] d, bit f, bit l, int lf);
    bit fired;
    in_valid = 1; in_data = d; in_first = f; in_last = l; in_len = LEN_W'(lf);
    do begin
      @(negedge clk); fired = in_ready;
      @(posedge clk); #1;
    end while (!fired);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic run_frame(int n, bit exp_drop, string req);
    logic [7:0] body[$];
    logic [7:0] exp[$];
    logic [31:0] crc;
    int bad = 0, fpos = 0, lpos = 0, wait_c = 0;
    cap.delete(); capf.delete(); capl.delete(); len_cnt = 0; hold_err = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = 8'((i * 37 + n * 5 + 1) & 8'hFF);
      body.push_back(v);
      push_byte(v, i == 0, i == n - 1, n);
    end
    while (len_cnt == 0 && wait_c < 3000) begin @(posedge clk); #1; wait_c++; end
    repeat (3) @(posedge clk); #1;
    chk(len_cnt == 1, {req, " report count"}, len_cnt, 1);
    if (exp_drop) begin
      chk(cap.size() == 0, "R7 no bytes on drop", cap.size(), 0);
      chk(last_len == 0 && last_drop, "R7 zero length and drop flag", last_len, 0);
      return;
    end
    for (int i = 0; i < 7; i++) exp.push_back(8'h55);
    exp.push_back(8'hD5);
    while (body.size() < 60) body.push_back(8'h00);
    crc = ref_crc(body);
    foreach (body[k]) exp.push_back(body[k]);
    for (int i = 0; i < 4; i++) exp.push_back(crc[8*i +: 8]);
    chk(cap.size() == exp.size(), {req, " R4 byte count"}, cap.size(), exp.size());
    for (int i = 0; i < exp.size() && i < cap.size(); i++) if (cap[i] != exp[i]) bad++;
    chk(bad == 0, {req, " R2 R3 R5 byte content"}, bad, 0);
    foreach (capf[k]) if (capf[k]) fpos++;
    foreach (capl[k]) if (capl[k]) lpos++;
    chk(fpos == 1 && capf.size() > 0 && capf[0], "R2 first marker", fpos, 1);
    chk(lpos == 1 && capl.size() > 0 && capl[capl.size()-1], "R5 last marker", lpos, 1);
    chk(last_len == body.size() + 12 && !last_drop, "R6 reported length", last_len, body.size() + 12);
    chk(hold_err == 0, "R8 stalled byte held", hold_err, 0);
  endtask

  task automatic test_reset();
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    chk(!in_ready, "R1 in_ready after reset", in_ready, 0);
    chk(!len_valid, "R1 len_valid after reset", len_valid, 0);
  endtask

  task automatic test_stray();
    cap.delete(); len_cnt = 0;
    push_byte(8'hA7, 0, 0, 5);
    repeat (20) @(posedge clk); #1;
    chk(cap.size() == 0 && len_cnt == 0, "R9 stray byte discarded", cap.size(), 0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    test_reset();
    @(posedge clk); #1;
    run_frame(64, 0, "R3 64B");
    run_frame(10, 0, "R4 10B pad");
    run_frame(60, 0, "R4 60B exact");
    run_frame(1, 0, "R4 1B pad");
    bp_en = 1;
    run_frame(20, 0, "R8 backpressure");
    bp_en = 0;
    @(posedge clk); #1;
    run_frame(116, 0, "R7 at limit");
    run_frame(117, 1, "R7 over limit");
    test_stray();
    run_frame(12, 0, "R9 after stray");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule